// File: doc/BRIEF.md
# NCO Phase Synchronization Controller

This block decides the clock cycle in which two numerically controlled oscillators, channel A and channel B, restart their phase accumulators. Several converters can then share one phase reference. Each channel has its own 32-bit tuning word and its own start phase. On a restart, each accumulator loads its start phase. On every other cycle it adds its tuning word.

A mode input chooses what triggers the restart. In link mode, the trigger is the return of the active-low link SYNC line to high after code-group synchronization, once the link has been enabled. In SYSREF mode, the trigger is a SYSREF rising edge, but only after a 0-to-1 transition of the arm input has armed the block. The arm is single-use: after it fires, later edges do nothing to the oscillators until the block is armed again.

Every SYSREF rising edge in either mode resets the local multiframe counter. SYSREF and SYNC each pass through a two-flop synchronizer, so the trigger latency is fixed. Two status outputs report the state of the block: one shows that it is armed, the other stays set after a restart.

Top module: `nco_phase_sync`

## Requirements
- R1: While `rst_n` is low, `acc_a`, `acc_b`, `mf_cnt`, `armed` and `sync_done` are all 0.
- R2: On a cycle with no restart, each accumulator adds its own tuning word, modulo 2^32. The two channels are independent.
- R3: With `sync_mode`=0, `arm_bit` going from 0 to 1 sets `armed` one clock later. Holding `arm_bit` at 1 never arms the block again.
- R4: In SYSREF mode, while armed, suppose `sysref_in` is first seen high at clock edge k. After edge k+2, `acc_a` and `acc_b` equal `phase_a` and `phase_b`, `armed` is 0 and `sync_done` is 1.
- R5: A SYSREF rising edge that arrives while the block is not armed leaves both accumulators counting on. It only resets `mf_cnt`.
- R6: An arm transition whose detection falls in the same cycle as a SYSREF edge detection does not fire on that edge. It sets `armed`, and the next SYSREF edge fires.
- R7: `mf_cnt` counts 0 to MF_PERIOD-1 and wraps. A SYSREF edge first seen at edge k makes `mf_cnt` 0 after edge k+2, and it then counts on from there.
- R8: With `sync_mode`=1 and `link_en`=1, suppose `sync_n_in` has been seen low and is then first seen high at edge k. After edge k+2, both accumulators hold their start phases and `sync_done` is 1.
- R9: In link mode, a restart happens only once per link enable. SYSREF edges do not restart the oscillators. Setting `link_en` to 0 clears `sync_done` one clock later.
- R10: In SYSREF mode, an arm transition clears `sync_done` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| freq_a | input | ACC_W | Channel A tuning word |
| phase_a | input | ACC_W | Channel A start phase |
| freq_b | input | ACC_W | Channel B tuning word |
| phase_b | input | ACC_W | Channel B start phase |
| link_en | input | 1 | Link enable |
| sync_mode | input | 1 | 1: link SYNC trigger, 0: armed SYSREF trigger |
| arm_bit | input | 1 | Arm request; a 0-to-1 change arms |
| sync_n_in | input | 1 | Link SYNC, active low, asynchronous |
| sysref_in | input | 1 | SYSREF, asynchronous |
| acc_a | output | ACC_W | Channel A phase accumulator |
| acc_b | output | ACC_W | Channel B phase accumulator |
| mf_cnt | output | $clog2(MF_PERIOD) | Local multiframe counter |
| mf_align | output | 1 | One-cycle pulse: multiframe counter realigned |
| armed | output | 1 | SYSREF trigger is armed |
| sync_done | output | 1 | Sticky flag: a restart has happened |

## Verification
The assertions check several things on every cycle. A restart loads both start phases on the next clock, and the accumulators step by their tuning words on all other cycles. No restart occurs in SYSREF mode while the block is unarmed, or in link mode with the link disabled. A fired arm clears, and `sync_done` sets. The multiframe counter stays in range and returns to zero after each detected edge. Only the bench scenarios can show the end-to-end latency from the pins, the single use of an arm across several SYSREF pulses, and the case of an arm that lands on the same cycle as an edge. The same holds for the rule of one restart per link enable, and for the clearing of `sync_done`.

// File: rtl/nps_pkg.sv
// Package: shared types for the NCO phase synchronization controller.
// Assumes: nothing beyond IEEE 1800-2017.
package nps_pkg;

    // Progress of the link-mode trigger through code-group synchronization
    typedef enum logic [1:0] {
        CS_IDLE,      // link disabled or SYSREF mode
        CS_WAIT_LOW,  // link enabled, waiting for SYNC to go low
        CS_CGS,       // SYNC low seen, waiting for its release
        CS_DONE       // restart issued for this link enable
    } cgs_state_t;

endpackage

// File: rtl/nps_sync2.sv
// Module: two-flop synchronizer for one asynchronous control line.
// Assumes: the input is a level held for at least two clock periods.
module nps_sync2 #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic meta_q;

    // Two-stage capture of the asynchronous input
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/nps_trigger.sv
// Module: decides the restart cycle from synchronized SYSREF and SYNC.
// Holds the one-shot arm, the sticky done flag and the link-mode state.
// Assumes: sysref_s and sync_s are already synchronized; arm_bit is synchronous.
module nps_trigger
    import nps_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sync_mode,
    input  logic link_en,
    input  logic arm_bit,
    input  logic sysref_s,
    input  logic sync_s,
    output logic fire,
    output logic sysref_rise,
    output logic armed,
    output logic done
);
    logic       arm_q, sysref_d, sync_d;
    logic       arm_rise, sync_rise, sref_fire, link_fire;
    cgs_state_t state_q, state_n;

    // Previous values for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_q    <= 1'b0;
            sysref_d <= 1'b0;
            sync_d   <= 1'b1;
        end else begin
            arm_q    <= arm_bit;
            sysref_d <= sysref_s;
            sync_d   <= sync_s;
        end
    end

    // Edge strobes and the two trigger sources
    always_comb begin
        arm_rise    = arm_bit & ~arm_q;
        sysref_rise = sysref_s & ~sysref_d;
        sync_rise   = sync_s & ~sync_d;
        sref_fire   = ~sync_mode & armed & sysref_rise;
        link_fire   = sync_mode & link_en & (state_q == CS_CGS) & sync_rise;
        fire        = sref_fire | link_fire;
    end

    // Next state of the link-mode sequence
    always_comb begin
        state_n = state_q;
        if (!sync_mode || !link_en) begin
            state_n = CS_IDLE;
        end else begin
            case (state_q)
                CS_IDLE:     state_n = CS_WAIT_LOW;
                CS_WAIT_LOW: if (!sync_s) state_n = CS_CGS;
                CS_CGS:      if (sync_rise) state_n = CS_DONE;
                default:     state_n = state_q;
            endcase
        end
    end

    // State, one-shot arm and sticky done registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CS_IDLE;
            armed   <= 1'b0;
            done    <= 1'b0;
        end else begin
            state_q <= state_n;
            if (sync_mode)     armed <= 1'b0;
            else if (arm_rise) armed <= 1'b1;
            else if (sref_fire) armed <= 1'b0;
            if (fire)                         done <= 1'b1;
            else if (!sync_mode && arm_rise)  done <= 1'b0;
            else if (sync_mode && !link_en)   done <= 1'b0;
        end
    end
endmodule

// File: rtl/nps_accum.sv
// Module: one phase accumulator; loads its start phase on a restart.
// Assumes: load is a single-cycle strobe.
module nps_accum #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [ACC_W-1:0] freq,
    input  logic [ACC_W-1:0] phase,
    output logic [ACC_W-1:0] acc
);
    // Restart to the start phase or step by the tuning word
    always_ff @(posedge clk) begin
        if (!rst_n)    acc <= '0;
        else if (load) acc <= phase;
        else           acc <= acc + freq;
    end
endmodule

// File: rtl/nps_mfc.sv
// Module: local multiframe counter with period MF_PERIOD, realigned by a strobe.
// Assumes: MF_PERIOD >= 2.
module nps_mfc #(
    parameter int MF_PERIOD = 16,
    localparam int MF_W = $clog2(MF_PERIOD)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            align,
    output logic [MF_W-1:0] cnt
);
    localparam logic [MF_W-1:0] LAST = MF_W'(MF_PERIOD - 1);

    // Count with wrap, or return to zero on realignment
    always_ff @(posedge clk) begin
        if (!rst_n || align) cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/nco_phase_sync.sv
// Module: NCO phase synchronization controller (top).
// Synchronizes SYSREF and SYNC, picks the restart trigger, restarts both
// phase accumulators and realigns the local multiframe counter.
// Assumes: register inputs are synchronous to clk; sysref_in and sync_n_in are not.
module nco_phase_sync #(
    parameter int ACC_W     = 32,
    parameter int MF_PERIOD = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ACC_W-1:0]             freq_a,
    input  logic [ACC_W-1:0]             phase_a,
    input  logic [ACC_W-1:0]             freq_b,
    input  logic [ACC_W-1:0]             phase_b,
    input  logic                         link_en,
    input  logic                         sync_mode,
    input  logic                         arm_bit,
    input  logic                         sync_n_in,
    input  logic                         sysref_in,
    output logic [ACC_W-1:0]             acc_a,
    output logic [ACC_W-1:0]             acc_b,
    output logic [$clog2(MF_PERIOD)-1:0] mf_cnt,
    output logic                         mf_align,
    output logic                         armed,
    output logic                         sync_done
);
    localparam int NUM_CH = 2;

    logic             sysref_s, sync_s, fire, sysref_rise;
    logic [ACC_W-1:0] freq_v  [NUM_CH];
    logic [ACC_W-1:0] phase_v [NUM_CH];
    logic [ACC_W-1:0] acc_v   [NUM_CH];

    nps_sync2 #(.RST_VAL(1'b0)) sref_sync_i (
        .clk(clk), .rst_n(rst_n), .d(sysref_in), .q(sysref_s));
    nps_sync2 #(.RST_VAL(1'b1)) link_sync_i (
        .clk(clk), .rst_n(rst_n), .d(sync_n_in), .q(sync_s));

    nps_trigger trig_i (
        .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .link_en(link_en),
        .arm_bit(arm_bit), .sysref_s(sysref_s), .sync_s(sync_s),
        .fire(fire), .sysref_rise(sysref_rise), .armed(armed), .done(sync_done));

    // Gather per-channel words into arrays
    always_comb begin
        freq_v[0]  = freq_a;
        freq_v[1]  = freq_b;
        phase_v[0] = phase_a;
        phase_v[1] = phase_b;
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        nps_accum #(.ACC_W(ACC_W)) acc_i (
            .clk(clk), .rst_n(rst_n), .load(fire),
            .freq(freq_v[ch]), .phase(phase_v[ch]), .acc(acc_v[ch]));
    end

    nps_mfc #(.MF_PERIOD(MF_PERIOD)) mfc_i (
        .clk(clk), .rst_n(rst_n), .align(sysref_rise), .cnt(mf_cnt));

    assign acc_a    = acc_v[0];
    assign acc_b    = acc_v[1];
    assign mf_align = sysref_rise;
endmodule

// File: rtl/nps_checker.sv
// Module: assertion checker for nco_phase_sync, attached by bind.
// Assumes: synchronous active-low reset; fire and sysref_rise are top-level nets.
module nps_checker #(
    parameter int ACC_W     = 32,
    parameter int MF_PERIOD = 16
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         sync_mode,
    input logic                         link_en,
    input logic                         arm_bit,
    input logic [ACC_W-1:0]             freq_a,
    input logic [ACC_W-1:0]             freq_b,
    input logic [ACC_W-1:0]             phase_a,
    input logic [ACC_W-1:0]             phase_b,
    input logic [ACC_W-1:0]             acc_a,
    input logic [ACC_W-1:0]             acc_b,
    input logic [$clog2(MF_PERIOD)-1:0] mf_cnt,
    input logic                         armed,
    input logic                         sync_done,
    input logic                         fire,
    input logic                         sysref_rise
);
    a_r4_load_phase: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (acc_a == $past(phase_a)) && (acc_b == $past(phase_b)));

    a_r2_step_freq: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> (acc_a == $past(acc_a) + $past(freq_a)) &&
                  (acc_b == $past(acc_b) + $past(freq_b)));

    a_r4_arm_consumed: assert property (@(posedge clk) disable iff (!rst_n)
        fire && !arm_bit |=> !armed);

    a_r4_done_set: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> sync_done);

    a_r5_no_fire_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_mode && !armed |-> !fire);

    a_r9_no_fire_link_off: assert property (@(posedge clk) disable iff (!rst_n)
        sync_mode && !link_en |-> !fire);

    a_r7_realign: assert property (@(posedge clk) disable iff (!rst_n)
        sysref_rise |=> mf_cnt == '0);

    a_r7_range: assert property (@(posedge clk) disable iff (!rst_n)
        32'(mf_cnt) < MF_PERIOD);
endmodule

bind nco_phase_sync nps_checker #(.ACC_W(ACC_W), .MF_PERIOD(MF_PERIOD)) chk_i (
    .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .link_en(link_en),
    .arm_bit(arm_bit), .freq_a(freq_a), .freq_b(freq_b),
    .phase_a(phase_a), .phase_b(phase_b), .acc_a(acc_a), .acc_b(acc_b),
    .mf_cnt(mf_cnt), .armed(armed), .sync_done(sync_done),
    .fire(fire), .sysref_rise(sysref_rise));

// File: tb/nco_phase_sync_tb_top.sv
// Scoreboard bench: the driver queues expected values with the cycle at which
// they are due; the monitor compares them on the falling edge.
module nco_phase_sync_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ACC_W      = 32;
    localparam int MF_P       = 5;
    localparam int K_ACCA = 0, K_ACCB = 1, K_MF = 2, K_ARMED = 3, K_DONE = 4;

    logic clk = 1'b0;
    logic rst_n;
    logic [ACC_W-1:0] freq_a, phase_a, freq_b, phase_b, acc_a, acc_b;
    logic link_en, sync_mode, arm_bit, sync_n_in, sysref_in, mf_align, armed, sync_done;
    logic [$clog2(MF_P)-1:0] mf_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    nco_phase_sync #(.ACC_W(ACC_W), .MF_PERIOD(MF_P)) dut_i (
        .clk(clk), .rst_n(rst_n), .freq_a(freq_a), .phase_a(phase_a),
        .freq_b(freq_b), .phase_b(phase_b), .link_en(link_en),
        .sync_mode(sync_mode), .arm_bit(arm_bit), .sync_n_in(sync_n_in),
        .sysref_in(sysref_in), .acc_a(acc_a), .acc_b(acc_b), .mf_cnt(mf_cnt),
        .mf_align(mf_align), .armed(armed), .sync_done(sync_done));

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int q_cyc[$];
    int q_kind[$];
    logic [31:0] q_val[$];
    string q_tag[$];
    int ba_cyc, bb_cyc;
    logic [31:0] ba_val, bb_val;

    // Edge counter used to time expectations
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] ea(int c);
        return ba_val + 32'(c - ba_cyc) * freq_a;
    endfunction

    function automatic logic [31:0] eb(int c);
        return bb_val + 32'(c - bb_cyc) * freq_b;
    endfunction

    function automatic void check(int kind, logic [31:0] exp_v, string tag);
        logic [31:0] act;
        case (kind)
            K_ACCA:  act = acc_a;
            K_ACCB:  act = acc_b;
            K_MF:    act = 32'(mf_cnt);
            K_ARMED: act = 32'(armed);
            default: act = 32'(sync_done);
        endcase
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s kind %0d at cycle %0d: actual %h expected %h",
                     tag, kind, cyc, act, exp_v);
        end
    endfunction

    task automatic push(int at, int kind, logic [31:0] v, string tag);
        q_cyc.push_back(at);
        q_kind.push_back(kind);
        q_val.push_back(v);
        q_tag.push_back(tag);
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rebase(int c, logic [31:0] pa, logic [31:0] pb);
        ba_cyc = c; ba_val = pa;
        bb_cyc = c; bb_val = pb;
    endtask

    // Monitor: pop and compare every item due in this cycle
    always @(negedge clk) begin
        for (int i = q_cyc.size() - 1; i >= 0; i--) begin
            if (q_cyc[i] == cyc) begin
                check(q_kind[i], q_val[i], q_tag[i]);
                q_cyc.delete(i);
                q_kind.delete(i);
                q_val.delete(i);
                q_tag.delete(i);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        rst_n = 1'b0; link_en = 1'b0; sync_mode = 1'b0; arm_bit = 1'b0;
        sync_n_in = 1'b1; sysref_in = 1'b0;
        freq_a = 32'h0000_0003; phase_a = 32'h1234_5678;
        freq_b = 32'h1000_0001; phase_b = 32'hCAFE_F00D;
        tick(3);
        // R1: reset state
        check(K_ACCA, 0, "R1"); check(K_ACCB, 0, "R1"); check(K_MF, 0, "R1");
        check(K_ARMED, 0, "R1"); check(K_DONE, 0, "R1");
        rst_n = 1'b1;
        rebase(cyc, 0, 0);
        // R2 free-running steps, R7 counting and wrap
        push(cyc + 5, K_ACCA, ea(cyc + 5), "R2");
        push(cyc + 5, K_ACCB, eb(cyc + 5), "R2");
        push(cyc + 7, K_MF, 2, "R7");
        push(cyc + 9, K_MF, 4, "R7");
        tick(10);
        // R5: unarmed SYSREF only realigns the multiframe counter
        n = cyc; sysref_in = 1'b1;
        push(n + 3, K_MF, 0, "R5");
        push(n + 3, K_ACCA, ea(n + 3), "R5");
        push(n + 3, K_ACCB, eb(n + 3), "R5");
        push(n + 5, K_MF, 2, "R7");
        tick(2); sysref_in = 1'b0; tick(6);
        // R3: arm transition, R10 done stays clear
        arm_bit = 1'b1; n = cyc;
        push(n + 1, K_ARMED, 1, "R3");
        push(n + 1, K_DONE, 0, "R10");
        tick(4);
        // R4: armed SYSREF restarts both channels
        n = cyc; sysref_in = 1'b1;
        rebase(n + 3, phase_a, phase_b);
        push(n + 3, K_ACCA, phase_a, "R4");
        push(n + 3, K_ACCB, phase_b, "R4");
        push(n + 3, K_ARMED, 0, "R4");
        push(n + 3, K_DONE, 1, "R4");
        push(n + 6, K_ACCA, ea(n + 6), "R2");
        tick(2); sysref_in = 1'b0; tick(6);
        // R5 / R3: second edge with arm held high does nothing to the NCOs
        n = cyc; sysref_in = 1'b1;
        push(n + 3, K_ACCA, ea(n + 3), "R5");
        push(n + 3, K_MF, 0, "R5");
        push(n + 3, K_ARMED, 0, "R3");
        push(n + 3, K_DONE, 1, "R5");
        tick(2); sysref_in = 1'b0; tick(6);
        // R6: arm detected in the same cycle as an edge waits for the next edge
        arm_bit = 1'b0; tick(3);
        n = cyc; sysref_in = 1'b1; tick(2); arm_bit = 1'b1;
        push(n + 3, K_ARMED, 1, "R6");
        push(n + 3, K_ACCA, ea(n + 3), "R6");
        push(n + 3, K_DONE, 0, "R10");
        tick(2); sysref_in = 1'b0; tick(6);
        n = cyc; sysref_in = 1'b1;
        rebase(n + 3, phase_a, phase_b);
        push(n + 3, K_ACCA, phase_a, "R6");
        push(n + 3, K_DONE, 1, "R4");
        tick(2); sysref_in = 1'b0; tick(6);
        // Link mode: new start phases written while link disabled
        arm_bit = 1'b0; sync_mode = 1'b1;
        phase_a = 32'h0BAD_CAFE; phase_b = 32'h7777_0001;
        push(cyc + 2, K_DONE, 0, "R9");
        tick(2);
        link_en = 1'b1; tick(2);
        sync_n_in = 1'b0; tick(2);
        // R9: SYSREF in link mode does not restart, R7 still realigns
        n = cyc; sysref_in = 1'b1;
        push(n + 3, K_ACCA, ea(n + 3), "R9");
        push(n + 3, K_MF, 0, "R7");
        tick(2); sysref_in = 1'b0; tick(4);
        // R8: SYNC release after code-group sync restarts both channels
        n = cyc; sync_n_in = 1'b1;
        rebase(n + 3, phase_a, phase_b);
        push(n + 3, K_ACCA, phase_a, "R8");
        push(n + 3, K_ACCB, phase_b, "R8");
        push(n + 3, K_DONE, 1, "R8");
        tick(6);
        // R9: a second SYNC dip in the same link enable does not restart
        sync_n_in = 1'b0; tick(4);
        n = cyc; sync_n_in = 1'b1;
        push(n + 3, K_ACCA, ea(n + 3), "R9");
        push(n + 3, K_ACCB, eb(n + 3), "R9");
        tick(6);
        // R9: disabling the link clears the done flag
        link_en = 1'b0; n = cyc;
        push(n + 1, K_DONE, 0, "R9");
        tick(4);
        for (int i = 0; i < q_cyc.size(); i++) begin
            errors++;
            $display("FAIL %s: expectation never compared, actual none expected %h",
                     q_tag[i], q_val[i]);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule